// File: doc/BRIEF.md
# Binary-Weighted Sub-Area Pixel Memory Sequencer

This block is the digital control for one display pixel whose electrode is split into six sub-areas of binary weight. Each sub-area is either fully on or fully off, so the six stored bits together set the gray level. The block has three operating modes. In normal mode the memory is disconnected and the pixel is written the usual way through its gate and data lines. In pre-still mode one select strobe per bit fires in order, and each strobe copies the current data-line bit into its slot of a six-bit store. In still mode the drivers outside the pixel are idle and the sub-area electrodes are driven only from the store.

While the block is in still mode, every frame alternates between true polarity and inverted polarity. In a true frame the electrodes carry the stored bits, the true-path control is high and the counter electrode is low. In an inverted frame the electrodes carry the complement of the stored bits, the inverted-path control is high and the counter electrode is high. The two path controls are never on together. Each swap from one path to the other passes through one cycle in which both are off.

Mode requests take effect only on a frame tick. Still mode can be entered only from pre-still, and only after all six bits have been loaded.

Top module: `subarea_mip_seq`

## Requirements
- R1: After reset the block is in normal mode, and all strobes, both path controls, the counter electrode and all six electrodes are low.
- R2: `mode_sel` is sampled only on a clock edge where `frame_tick` is high. The codes are 2'b00 normal, 2'b01 pre-still, 2'b10 still and 2'b11 keep the current mode. Between ticks a changed request has no effect.
- R3: On entry to pre-still the load restarts at strobe 0. Each cycle with `row_gate` high drives exactly one strobe, in the order bit 0 to bit 5, and on that edge `line_bit` is copied into store bit k. Cycles with `row_gate` low drive no strobe and load nothing. No strobe fires after the sixth bit.
- R4: A still request is honoured only when the current mode is pre-still and all six bits are loaded. In every other case the mode is left unchanged.
- R5: The first still frame is a true frame: `pol_true` goes high on the clock edge after the tick edge that enters still mode.
- R6: Each later frame tick in still mode swaps the polarity. The active control drops on the edge after the tick, and the other control rises one edge later.
- R7: `pol_true` and `pol_inv` are never high in the same cycle, and neither rises in the cycle right after the other was high.
- R8: `com_level` is high exactly while `pol_inv` is high, and low in true frames and in dead cycles.
- R9: Electrode bit k (sub-area weight 2^k) equals store bit k while `pol_true` is high, its complement while `pol_inv` is high, and 0 otherwise.
- R10: Outside still mode both path controls stay low. Leaving still mode clears them on the edge after the tick.
- R11: The stored bits are kept through still and normal mode, so they are unchanged when still mode is entered again after a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested mode: 00 normal, 01 pre-still, 10 still, 11 keep |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| line_bit | input | 1 | Data-line bit |
| row_gate | input | 1 | Gate-line enable; qualifies each load step |
| sel_strobe | output | 6 | One-hot load strobes, bit k selects store slot k |
| pol_true | output | 1 | True-data path control |
| pol_inv | output | 1 | Inverted-data path control |
| com_level | output | 1 | Counter-electrode level |
| elec | output | 6 | Sub-area electrode levels, bit k has weight 2^k |

## Verification
Some rules hold on every cycle, and the assertions check those. The two path controls are never both high, and a dead cycle comes between them. At most one strobe is active at a time. Still mode is reached only from a fully loaded pre-still state. The store does not change while in still mode. Both controls stay low outside still mode.

Other behaviour can only be shown by the bench's scenarios. These include the exact cycle on which polarity swaps, the electrode values in true and inverted frames for two different bit patterns, and that requests are ignored between ticks. The bench also shows that a partial load blocks still entry, and that a low gate pauses the strobe sequence.

// File: rtl/subarea_mip_seq.sv
module subarea_mip_seq #(
  parameter int NBITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             frame_tick,
  input  logic             line_bit,
  input  logic             row_gate,
  output logic [NBITS-1:0] sel_strobe,
  output logic             pol_true,
  output logic             pol_inv,
  output logic             com_level,
  output logic [NBITS-1:0] elec
);
  localparam int IW = $clog2(NBITS + 1);

  typedef enum logic [1:0] {M_NORM = 2'b00, M_PRE = 2'b01, M_STILL = 2'b10} mode_t;

  mode_t           mode;
  logic [IW-1:0]   idx;
  logic [NBITS-1:0] store;
  logic            phase;

  wire load_done = (idx == IW'(NBITS));
  wire cap       = (mode == M_PRE) && row_gate && !load_done;
  wire enter_pre = frame_tick && (mode_sel == 2'b01) && (mode != M_PRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_NORM;
    end else if (frame_tick) begin
      case (mode_sel)
        2'b00: mode <= M_NORM;
        2'b01: mode <= M_PRE;
        2'b10: if (mode == M_PRE && load_done) mode <= M_STILL;
        default: mode <= mode;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         idx <= '0;
    else if (enter_pre) idx <= '0;
    else if (cap)       idx <= idx + 1'b1;
  end

  genvar k;
  generate
    for (k = 0; k < NBITS; k++) begin : g_slot
      assign sel_strobe[k] = cap && (idx == IW'(k));
      always_ff @(posedge clk) begin
        if (!rst_n)             store[k] <= 1'b0;
        else if (sel_strobe[k]) store[k] <= line_bit;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || mode != M_STILL) phase <= 1'b0;
    else if (frame_tick)           phase <= ~phase;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_true <= 1'b0;
      pol_inv  <= 1'b0;
    end else begin
      pol_true <= (mode == M_STILL) && !phase && !pol_inv;
      pol_inv  <= (mode == M_STILL) &&  phase && !pol_true;
    end
  end

  assign com_level = pol_inv;
  assign elec = pol_true ? store : (pol_inv ? ~store : '0);

  AST_POL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pol_true && pol_inv)); // R7
  AST_DEAD_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    pol_true |=> !pol_inv); // R7
  AST_DEAD_INV: assert property (@(posedge clk) disable iff (!rst_n)
    pol_inv |=> !pol_true); // R7
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_strobe)); // R3
  AST_STILL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_STILL) ##1 (mode == M_STILL) |-> $past(mode == M_PRE) && $past(load_done)); // R4
  AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STILL) |=> $stable(store)); // R11
  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_STILL) ##1 (mode != M_STILL) |-> !pol_true && !pol_inv); // R10
endmodule

// File: tb/subarea_mip_seq_test.sv
module subarea_mip_seq_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode_sel = 2'b00;
  logic frame_tick = 0, line_bit = 0, row_gate = 0;
  logic [5:0] sel_strobe, elec;
  logic pol_true, pol_inv, com_level;
  int n_cmp = 0, n_bad = 0;

  subarea_mip_seq uut (.clk, .rst_n, .mode_sel, .frame_tick, .line_bit, .row_gate,
                       .sel_strobe, .pol_true, .pol_inv, .com_level, .elec);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic outs(string req, logic pt, logic pi, logic [5:0] el);
    chk(req, {pol_true, pol_inv, com_level}, {pt, pi, pi});
    chk(req, elec, el);
  endtask

  task automatic tick(logic [1:0] m);
    mode_sel = m; frame_tick = 1;
    @(negedge clk); frame_tick = 0;
  endtask

  task automatic load(logic [5:0] v, int from, int upto, bit gap);
    for (int k = from; k < upto; k++) begin
      if (gap) begin
        row_gate = 0; line_bit = ~v[k]; #1;
        chk("R3 paused strobe", sel_strobe, 0);
        @(negedge clk);
      end
      row_gate = 1; line_bit = v[k]; #1;
      chk("R3 strobe order", sel_strobe, 6'd1 << k);
      @(negedge clk);
    end
    row_gate = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
    outs("R1 reset", 0, 0, 0);
    chk("R1 strobes", sel_strobe, 0);
  endtask

  task automatic t_still_from_normal();
    tick(2'b10); @(negedge clk); @(negedge clk);
    outs("R4 still from normal ignored", 0, 0, 0);
  endtask

  task automatic t_partial_then_still();
    tick(2'b01);
    row_gate = 1; #1; chk("R2 pre-still entered", sel_strobe, 6'd1); row_gate = 0;
    load(6'b101101, 0, 3, 0);
    tick(2'b10); @(negedge clk);
    outs("R4 partial load blocks still", 0, 0, 0);
    load(6'b101101, 3, 6, 0);
    row_gate = 1; #1; chk("R3 no strobe after six", sel_strobe, 0); row_gate = 0;
    tick(2'b10);
    outs("R5 entry edge no pol yet", 0, 0, 0);
    @(negedge clk);
    outs("R5 R9 true frame", 1, 0, 6'b101101);
  endtask

  task automatic t_alternate(logic [5:0] v);
    mode_sel = 2'b00; repeat (3) @(negedge clk);
    outs("R2 mid-frame request ignored", 1, 0, v);
    tick(2'b10);
    outs("R6 true held on tick edge", 1, 0, v);
    @(negedge clk);
    outs("R7 dead cycle", 0, 0, 0);
    @(negedge clk);
    outs("R6 R8 R9 inverted frame", 0, 1, ~v);
    tick(2'b11);
    @(negedge clk);
    outs("R7 dead cycle back", 0, 0, 0);
    @(negedge clk);
    outs("R6 R9 true again", 1, 0, v);
  endtask

  task automatic t_leave();
    tick(2'b00); @(negedge clk);
    outs("R10 normal clears pol", 0, 0, 0);
    tick(2'b10); @(negedge clk); @(negedge clk);
    outs("R4 still from normal after load", 0, 0, 0);
  endtask

  task automatic t_reload();
    tick(2'b01);
    load(6'b010011, 0, 6, 1);
    tick(2'b10); @(negedge clk);
    outs("R11 R9 new pattern true", 1, 0, 6'b010011);
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_still_from_normal();
    t_partial_then_still();
    t_alternate(6'b101101);
    t_leave();
    t_reload();
    t_alternate(6'b010011);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule